// File: doc/BRIEF.md
# Conditional Sum Adder

A purely combinational two-operand adder built as a carry-select tree. For every bit above the lowest, a sum and a carry-out are worked out in advance for both possible incoming carries. Levels of 2:1 selectors then merge neighbouring blocks. Each merge uses the resolved carry of the lower block to pick the upper block's candidates. Block size starts at one bit and doubles at each level until one block spans the whole word. The tree depth is therefore the ceiling of log2 of the width, not the width itself.

The operands may have different widths. Both are widened to N, the larger of the two widths. A parameter chooses whether the operands are unsigned or two's complement, and that choice sets how the narrower operand is widened. The result has N+1 bits. In unsigned mode the top bit is the final carry. In signed mode the top bit is corrected so that the result is the exact sign-extended sum. Any N is allowed, including widths that are not a power of two; the top partial block merges like any other.

Top module: `cond_sum_adder`

## Requirements
- R1: Result bit 0 is always op_a[0] XOR op_b[0]. The lowest bit sees a constant zero carry-in and needs no selection.
- R2: With SIGNED_MODE = 0, the result equals the unsigned sum op_a + op_b, taken to N+1 bits.
- R3: With SIGNED_MODE = 1, the result read as an N+1-bit two's-complement number equals the signed sum of the two operands.
- R4: The narrower operand is widened by filling with zeros in unsigned mode and by copying its top bit in signed mode. Example at N = 8 with a 6-bit op_b: op_a = 0 and op_b = 6'h3F give 9'h03F unsigned and 9'h1FF signed.
- R5: In unsigned mode, result bit N is set exactly when the sum is 2^N or more. Example: 8'hFF + 6'h01 gives 9'h100.
- R6: In signed mode, result bit N equals the operands' common top bit when their signs agree, and equals result bit N-1 when their signs differ. Examples: 8'h80 + 6'h20 gives 9'h160; 8'h7F + 6'h1F gives 9'h09E.
- R7: The sum is correct for a width that is not a power of two. Example: 13'h1FFF + 10'h001 gives 14'h2000.
- R8: The result depends only on the present operands, with no state and no clock. The same inputs give the same result whatever came before.
- R9: A carry that propagates across every bit position resolves correctly. In signed mode, 8'hFF + 6'h01 gives 9'h000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH_A | First operand |
| op_b | input | WIDTH_B | Second operand |
| result | output | max(WIDTH_A, WIDTH_B)+1 | Sum; the top bit is the carry (unsigned) or the sign (signed) |

## Verification
Two functions can act on the same input: carry resolution across the full length of the tree, and the sign correction of the top bit. The bench provokes both at once with operands whose carry propagates through every bit while the signs differ (8'hFF + 6'h01). It also uses operands of equal sign that overflow N bits (8'h80 + 6'h20 and 8'h7F + 6'h1F). Each result is judged against a behavioural integer sum at N+1 bits in both signedness modes. The exhaustive sweep over the 8-by-6-bit operand space covers every mixture of widening, full-length propagation and sign correction.

// File: rtl/cosa_pkg.sv
package cosa_pkg;

    // Larger of two operand widths: the common working width.
    function automatic int max_of(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

    // Number of merge levels needed to cover a word of n bits.
    function automatic int merge_levels(input int n);
        return (n <= 1) ? 0 : $clog2(n);
    endfunction

endpackage

// File: rtl/cosa_bit_cell.sv
// Per-bit dual full adder: candidates for carry-in 0 and carry-in 1.
// The lowest bit has a constant zero carry, so both candidates are the same.
module cosa_bit_cell #(
    parameter bit LSB_ONLY = 1'b0
) (
    input  logic in_a,
    input  logic in_b,
    output logic sum_c0,
    output logic sum_c1,
    output logic cy_c0,
    output logic cy_c1
);
    logic half_x;
    logic half_g;

    assign half_x = in_a ^ in_b;
    assign half_g = in_a & in_b;

    assign sum_c0 = half_x;
    assign cy_c0  = half_g;

    generate
        if (LSB_ONLY) begin : g_lsb
            assign sum_c1 = half_x;
            assign cy_c1  = half_g;
        end else begin : g_dual
            assign sum_c1 = ~half_x;
            assign cy_c1  = half_g | half_x;
        end
    endgenerate
endmodule

// File: rtl/cosa_merge_level.sv
// One level of the tree. Blocks of SZ bits are merged in pairs. The upper
// block's candidates are chosen by the carry out of the lower block.
module cosa_merge_level #(
    parameter int N  = 8,
    parameter int LV = 0
) (
    input  logic [N-1:0] s0_i,
    input  logic [N-1:0] s1_i,
    input  logic [N-1:0] c0_i,
    input  logic [N-1:0] c1_i,
    output logic [N-1:0] s0_o,
    output logic [N-1:0] s1_o,
    output logic [N-1:0] c0_o,
    output logic [N-1:0] c1_o
);
    localparam int SZ      = 1 << LV;
    localparam int NBLK_IN = (N + SZ - 1) / SZ;
    localparam int NBLK_OUT = (NBLK_IN + 1) / 2;

    always_comb begin
        s0_o = s0_i;
        s1_o = s1_i;
        c0_o = '0;
        c1_o = '0;
        // Sum selection: only bits sitting in an odd-numbered block move.
        for (int i = 0; i < N; i++) begin
            if (((i / SZ) % 2) == 1) begin
                s0_o[i] = c0_i[(i / SZ) - 1] ? s1_i[i] : s0_i[i];
                s1_o[i] = c1_i[(i / SZ) - 1] ? s1_i[i] : s0_i[i];
            end
        end
        // Carry merge: a lone trailing block passes straight up.
        for (int j = 0; j < NBLK_OUT; j++) begin
            if ((2 * j + 1) < NBLK_IN) begin
                c0_o[j] = c0_i[2 * j] ? c1_i[2 * j + 1] : c0_i[2 * j + 1];
                c1_o[j] = c1_i[2 * j] ? c1_i[2 * j + 1] : c0_i[2 * j + 1];
            end else begin
                c0_o[j] = c0_i[2 * j];
                c1_o[j] = c1_i[2 * j];
            end
        end
    end

    // A carry assuming carry-in 1 is never below the one assuming carry-in 0.
    always_comb begin
        AST_CARRY_MONO: assert ((c0_i & ~c1_i) == '0 && (c0_o & ~c1_o) == '0 && (s0_i | s1_i | ~s0_i | ~s1_i) != '0); // R5
    end
endmodule

// File: rtl/cosa_sign_fix.sv
// Top result bit: the plain carry, or a corrected sign in two's complement.
module cosa_sign_fix #(
    parameter bit SIGNED_MODE = 1'b1
) (
    input  logic a_msb,
    input  logic b_msb,
    input  logic carry_n,
    output logic top_bit
);
    generate
        if (SIGNED_MODE) begin : g_signed
            assign top_bit = a_msb ^ b_msb ^ carry_n;
        end else begin : g_unsigned
            logic unused_msbs;
            assign unused_msbs = a_msb ^ b_msb;
            assign top_bit     = carry_n;
        end
    endgenerate
endmodule

// File: rtl/cond_sum_adder.sv
module cond_sum_adder #(
    parameter int WIDTH_A     = 8,
    parameter int WIDTH_B     = 6,
    parameter bit SIGNED_MODE = 1'b1
) (
    input  logic [WIDTH_A-1:0]                           op_a,
    input  logic [WIDTH_B-1:0]                           op_b,
    output logic [cosa_pkg::max_of(WIDTH_A, WIDTH_B):0]  result
);
    localparam int N      = cosa_pkg::max_of(WIDTH_A, WIDTH_B);
    localparam int LEVELS = cosa_pkg::merge_levels(N);

    logic [N-1:0] ext_a;
    logic [N-1:0] ext_b;
    logic [N-1:0] lv_s0 [0:LEVELS];
    logic [N-1:0] lv_s1 [0:LEVELS];
    logic [N-1:0] lv_c0 [0:LEVELS];
    logic [N-1:0] lv_c1 [0:LEVELS];
    logic [N:0]   ref_sum;

    // Widening: zero fill unsigned, top-bit copy signed.
    always_comb begin
        ext_a = {N{SIGNED_MODE & op_a[WIDTH_A-1]}};
        ext_b = {N{SIGNED_MODE & op_b[WIDTH_B-1]}};
        ext_a[WIDTH_A-1:0] = op_a;
        ext_b[WIDTH_B-1:0] = op_b;
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_cell
            cosa_bit_cell #(.LSB_ONLY(i == 0)) u_cell (
                .in_a   (ext_a[i]),
                .in_b   (ext_b[i]),
                .sum_c0 (lv_s0[0][i]),
                .sum_c1 (lv_s1[0][i]),
                .cy_c0  (lv_c0[0][i]),
                .cy_c1  (lv_c1[0][i])
            );
        end
        for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
            cosa_merge_level #(.N(N), .LV(lv)) u_level (
                .s0_i (lv_s0[lv]),
                .s1_i (lv_s1[lv]),
                .c0_i (lv_c0[lv]),
                .c1_i (lv_c1[lv]),
                .s0_o (lv_s0[lv+1]),
                .s1_o (lv_s1[lv+1]),
                .c0_o (lv_c0[lv+1]),
                .c1_o (lv_c1[lv+1])
            );
        end
    endgenerate

    cosa_sign_fix #(.SIGNED_MODE(SIGNED_MODE)) u_fix (
        .a_msb   (ext_a[N-1]),
        .b_msb   (ext_b[N-1]),
        .carry_n (lv_c0[LEVELS][0]),
        .top_bit (result[N])
    );

    assign result[N-1:0] = lv_s0[LEVELS];

    // Behavioural sum at N+1 bits, used only by the checks below.
    assign ref_sum = {SIGNED_MODE & ext_a[N-1], ext_a} + {SIGNED_MODE & ext_b[N-1], ext_b};

    always_comb begin
        AST_LSB_FINAL: assert (result[0] == (op_a[0] ^ op_b[0])); // R1
        AST_ROOT_FINAL: assert (lv_c0[LEVELS] == lv_c1[LEVELS] && lv_s0[LEVELS] == lv_s1[LEVELS]); // R8
        if (!SIGNED_MODE) begin
            AST_UNS_SUM: assert (result == ref_sum); // R2
        end else begin
            AST_SGN_SUM: assert (result == ref_sum); // R3
            AST_SIGN_EXT: assert (result[N] == ((ext_a[N-1] == ext_b[N-1]) ? ext_a[N-1] : result[N-1])); // R6
        end
    end
endmodule

// File: tb/cond_sum_adder_test.sv
module cond_sum_adder_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_checks = 0;
    int   n_fails = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    logic [7:0]  a8;
    logic [5:0]  b6;
    logic [12:0] aw;
    logic [9:0]  bw;
    logic [8:0]  res_s;
    logic [8:0]  res_u;
    logic [13:0] res_w;

    cond_sum_adder #(.WIDTH_A(8), .WIDTH_B(6), .SIGNED_MODE(1'b1)) uut (
        .op_a(a8), .op_b(b6), .result(res_s));
    cond_sum_adder #(.WIDTH_A(8), .WIDTH_B(6), .SIGNED_MODE(1'b0)) uut_uns (
        .op_a(a8), .op_b(b6), .result(res_u));
    cond_sum_adder #(.WIDTH_A(13), .WIDTH_B(10), .SIGNED_MODE(1'b0)) uut_wide (
        .op_a(aw), .op_b(bw), .result(res_w));

    task automatic chk(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // Drive just after a rising edge; results are sampled at the falling edge.
    task automatic apply(input logic [7:0] a, input logic [5:0] b,
                         input logic [12:0] wa, input logic [9:0] wb);
        @(posedge clk);
        #1;
        a8 = a; b6 = b; aw = wa; bw = wb;
        @(negedge clk);
    endtask

    function automatic int ref_signed(input logic [7:0] a, input logic [5:0] b);
        int ia;
        int ib;
        ia = $signed(a);
        ib = $signed(b);
        return (ia + ib) & 'h1FF;
    endfunction

    initial begin
        a8 = '0; b6 = '0; aw = '0; bw = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Zero inputs straight after reset release.
        chk("R8 zero signed", int'(res_s), 0);
        chk("R8 zero unsigned", int'(res_u), 0);
        chk("R8 zero wide", int'(res_w), 0);

        apply(8'h01, 6'h00, 13'h0, 10'h0);
        chk("R1 lsb one", int'(res_s), 'h001);
        apply(8'h01, 6'h01, 13'h0, 10'h0);
        chk("R1 lsb zero", int'(res_u), 'h002);

        apply(8'hFF, 6'h01, 13'h1FFF, 10'h001);
        chk("R9 full carry signed", int'(res_s), 'h000);
        chk("R5 carry out unsigned", int'(res_u), 'h100);
        chk("R7 non-power-of-two width", int'(res_w), 'h2000);

        apply(8'h80, 6'h20, 13'h0, 10'h3FF);
        chk("R6 negative overflow", int'(res_s), 'h160);
        chk("R2 unsigned directed", int'(res_u), 'h0A0);
        chk("R4 zero fill wide", int'(res_w), 'h3FF);

        apply(8'h7F, 6'h1F, 13'h0, 10'h0);
        chk("R6 positive overflow", int'(res_s), 'h09E);

        apply(8'h00, 6'h3F, 13'h0, 10'h0);
        chk("R4 sign fill", int'(res_s), 'h1FF);
        chk("R4 zero fill", int'(res_u), 'h03F);

        // Exhaustive sweep of the 8x6 space, random wide operands per cycle.
        for (int ai = 0; ai < 256; ai++) begin
            for (int bi = 0; bi < 64; bi++) begin
                logic [12:0] ra;
                logic [9:0]  rb;
                ra = 13'($urandom);
                rb = 10'($urandom);
                apply(8'(ai), 6'(bi), ra, rb);
                chk("R3 signed sweep", int'(res_s), ref_signed(8'(ai), 6'(bi)));
                chk("R2 unsigned sweep", int'(res_u), (ai + bi) & 'h1FF);
                chk("R7 wide random", int'(res_w), (int'(ra) + int'(rb)) & 'h3FFF);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule